// File: doc/BRIEF.md
# Buffered Clock Prescaler

This block turns the timer input clock into a one-cycle counting tick for a time-base counter. It divides the clock by a programmable factor, the 16-bit ratio register plus one, so the tick fires once every 1 to 65536 enabled cycles. The tick only advances while the counter enable is high.

The ratio register is double-buffered. Software may write the preload copy at any moment, including while the divider is counting. The active copy that the divider compares against changes only when an update event arrives. An update event is either the external update strobe or the software update strobe. The software update also restarts the internal count from zero.

The write port is a plain register port with no back-pressure: a write strobe is taken in the cycle it is high. The read port always shows the preload copy.

Top module: `presc_tick`

## Requirements
- R1: With an active ratio N, the tick is high for exactly one enabled cycle in every N+1 enabled cycles, and the internal count returns to 0 after each tick.
- R2: With an active ratio of 0, the tick is high on every enabled cycle that has no software update.
- R3: A write strobe stores `reg_wdata` into the preload copy at the clock edge, at any time, and `reg_rdata` shows the preload copy, not the active one.
- R4: A write does not change the division in use. The active ratio takes the preload value only at the edge that samples `upd_evt` or `sw_upd` high.
- R5: A software update restarts the internal count at 0 at its edge, and the tick is low in the cycle the strobe is high.
- R6: While `count_en` is low the tick stays low and the internal count holds its value.
- R7: After reset the preload ratio, the active ratio and the internal count are all 0.
- R8: If the active ratio becomes smaller than the current internal count, the tick fires on the next enabled cycle and the count wraps to 0.
- R9: When a write and an update happen in the same cycle, the active ratio takes the preload value from before that write.
- R10: An active ratio of 0xFFFF gives one tick every 65536 enabled cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| count_en | input | 1 | Counter enable; the divider runs only while high |
| reg_wr | input | 1 | Write strobe for the ratio register |
| reg_wdata | input | 16 | Ratio value to store in the preload copy |
| reg_rdata | output | 16 | Current preload ratio |
| upd_evt | input | 1 | External update-event strobe |
| sw_upd | input | 1 | Software update strobe; loads the ratio and restarts the count |
| tick | output | 1 | One-cycle counting enable |

## Verification
The tick is combinational from the registered count and active ratio, so it is due in the same cycle as the enable and strobes that qualify it. A write shows on `reg_rdata` one cycle after its edge, and an update or restart affects the tick from the cycle after its edge. The bench drives inputs on the falling edge and compares the outputs with a behavioural model one time unit later. It advances the model at the rising edge, so every check falls in the cycle where the result is due.

// File: rtl/presc_pkg.sv
package presc_pkg;
  // Default width of the ratio register and of the internal divider count.
  localparam int unsigned RATIO_W_DEF = 16;

  // Reached-limit test shared by the divider: a count at or past the limit ends a period.
  function automatic logic at_limit(input logic [31:0] cnt, input logic [31:0] lim);
    return cnt >= lim;
  endfunction
endpackage

// File: rtl/ratio_buffer.sv
module ratio_buffer #(
  parameter int unsigned W = presc_pkg::RATIO_W_DEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         load,
  output logic [W-1:0] preload_q,
  output logic [W-1:0] active_q
);
  // Preload copy: written by software at any time.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     preload_q <= '0;
    else if (wr_en) preload_q <= wr_data;
  end

  // Active copy: takes the preload value present before this edge's write.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    active_q <= '0;
    else if (load) active_q <= preload_q;
  end

  p_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> preload_q == $past(wr_data));
  p_hold_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(active_q));
  p_load_old_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> active_q == $past(preload_q));
endmodule

// File: rtl/div_counter.sv
module div_counter #(
  parameter int unsigned W = presc_pkg::RATIO_W_DEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         restart,
  input  logic [W-1:0] limit,
  output logic         tick
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;
  logic         reached;

  assign reached = presc_pkg::at_limit(32'(cnt_q), 32'(limit));
  assign tick    = en && !restart && reached;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else if (en)      cnt_q <= reached ? '0 : cnt_q + ONE;
  end

  p_tick_needs_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> en);
  p_hold_when_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !restart) |=> $stable(cnt_q));
  p_restart_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> cnt_q == '0);
  p_wrap_after_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> cnt_q == '0);
  p_no_tick_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    restart |-> !tick);
endmodule

// File: rtl/presc_tick.sv
module presc_tick #(
  parameter int unsigned RATIO_W = presc_pkg::RATIO_W_DEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               count_en,
  input  logic               reg_wr,
  input  logic [RATIO_W-1:0] reg_wdata,
  output logic [RATIO_W-1:0] reg_rdata,
  input  logic               upd_evt,
  input  logic               sw_upd,
  output logic               tick
);
  logic               any_update;
  logic [RATIO_W-1:0] preload;
  logic [RATIO_W-1:0] active;

  assign any_update = upd_evt | sw_upd;
  assign reg_rdata  = preload;

  ratio_buffer #(.W(RATIO_W)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (reg_wr),
    .wr_data   (reg_wdata),
    .load      (any_update),
    .preload_q (preload),
    .active_q  (active)
  );

  div_counter #(.W(RATIO_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (count_en),
    .restart (sw_upd),
    .limit   (active),
    .tick    (tick)
  );

  p_tick_quiet_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !count_en |-> !tick);
  p_read_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> $stable(reg_rdata));
endmodule

// File: tb/presc_tick_test.sv
module presc_tick_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        count_en = 1'b0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        upd_evt = 1'b0;
  logic        sw_upd = 1'b0;
  logic        tick;

  int n_checks = 0;
  int n_errors = 0;
  int tick_seen = 0;
  bit done = 1'b0;

  // Behavioural model state
  int m_pre = 0;
  int m_act = 0;
  int m_cnt = 0;

  always #5 clk = ~clk;

  presc_tick uut (
    .clk(clk), .rst_n(rst_n), .count_en(count_en), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .upd_evt(upd_evt),
    .sw_upd(sw_upd), .tick(tick)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Drive one cycle at the falling edge, check, then advance the model at the rising edge.
  task automatic step(input bit en, input bit wr, input int wd, input bit ue, input bit sw,
                      input string tag);
    bit exp_tick;
    count_en = en; reg_wr = wr; reg_wdata = wd[15:0]; upd_evt = ue; sw_upd = sw;
    #1;
    exp_tick = en && !sw && (m_cnt >= m_act);
    check(tick == exp_tick, {tag, " tick"}, int'(tick), int'(exp_tick));
    check(int'(reg_rdata) == m_pre, {tag, " R3 rdata"}, int'(reg_rdata), m_pre);
    if (tick) tick_seen++;
    @(posedge clk);
    if (sw) m_cnt = 0;
    else if (en) m_cnt = exp_tick ? 0 : m_cnt + 1;
    if (ue || sw) m_act = m_pre;
    if (wr) m_pre = wd;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_errors++; n_checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R7: reset state; active 0 so the first enabled cycle ticks
    step(1, 0, 0, 0, 0, "R7 reset");

    // R2: ratio 0 ticks on every enabled cycle
    tick_seen = 0;
    for (int i = 0; i < 5; i++) step(1, 0, 0, 0, 0, "R2 ratio0");
    check(tick_seen == 5, "R2 tick count", tick_seen, 5);

    // R3/R4: write 3 while running; division unchanged until an update
    step(1, 1, 3, 0, 0, "R3 write");
    tick_seen = 0;
    for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 0, "R4 no update");
    check(tick_seen == 4, "R4 still ratio0", tick_seen, 4);

    // R4: external update loads the ratio; R1: one tick every 4 cycles
    step(1, 0, 0, 1, 0, "R4 upd_evt");
    tick_seen = 0;
    for (int i = 0; i < 12; i++) step(1, 0, 0, 0, 0, "R1 div4");
    check(tick_seen == 3, "R1 tick count", tick_seen, 3);

    // R6: enable low holds the count
    step(1, 0, 0, 0, 0, "R6 pre");
    tick_seen = 0;
    for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 0, "R6 disabled");
    check(tick_seen == 0, "R6 no tick", tick_seen, 0);
    for (int i = 0; i < 6; i++) step(1, 0, 0, 0, 0, "R6 resume");

    // R5: software update restarts the count mid-period
    step(1, 0, 0, 0, 0, "R5 pre");
    step(1, 0, 0, 0, 1, "R5 sw_upd");
    tick_seen = 0;
    for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 0, "R5 after restart");
    check(tick_seen == 1, "R5 one tick", tick_seen, 1);

    // R9: write 7 with update in the same cycle: active keeps old preload 3
    step(1, 1, 7, 1, 0, "R9 wr+upd");
    tick_seen = 0;
    for (int i = 0; i < 8; i++) step(1, 0, 0, 0, 0, "R9 still div4");
    check(tick_seen == 2, "R9 tick count", tick_seen, 2);
    step(1, 0, 0, 1, 0, "R9 load 7");
    tick_seen = 0;
    for (int i = 0; i < 16; i++) step(1, 0, 0, 0, 0, "R1 div8");
    check(tick_seen == 2, "R1 div8 count", tick_seen, 2);

    // R8: shrink ratio below current count
    step(1, 0, 0, 0, 1, "R8 restart");
    for (int i = 0; i < 5; i++) step(1, 0, 0, 0, 0, "R8 run");
    step(1, 1, 1, 0, 0, "R8 write1");
    step(1, 0, 0, 1, 0, "R8 upd");
    step(1, 0, 0, 0, 0, "R8 immediate tick");
    tick_seen = 0;
    for (int i = 0; i < 6; i++) step(1, 0, 0, 0, 0, "R8 div2");
    check(tick_seen == 3, "R8 div2 count", tick_seen, 3);

    // R10: largest ratio, 65536 cycles per tick
    step(1, 1, 16'hFFFF, 0, 0, "R10 write");
    step(1, 0, 0, 0, 1, "R10 sw_upd");
    tick_seen = 0;
    for (int i = 0; i < 65536; i++) step(1, 0, 0, 0, 0, "R10 run");
    check(tick_seen == 1, "R10 tick count", tick_seen, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule